// File: doc/BRIEF.md
# Seven-Segment Digit Row with Zero Blanking

This block drives a row of seven-segment digits from packed BCD values. The row has an integer part and a fraction part. Each digit goes through a decoder that maps a 4-bit BCD code to seven active-low segment lines. The decoder also has three controls: a lamp test, a blanking input, and a ripple-blanking input/output pair.

Inside the row, the ripple-blanking signals are chained from digit to digit. In the integer part, zeros that stand to the left of the most significant nonzero digit go dark. In the fraction part, zeros that stand to the right of the last nonzero digit go dark. The units digit and the first fraction digit always stay visible, so a zero value still reads "0.0".

The segment lines are registered once before they leave the block, and a synchronous reset blanks them.

Top module: `seg_display`

## Requirements
- R1: Segment order inside each 7-bit digit field is bit 6 = a down to bit 0 = g, and 0 lights a segment. With no control active, codes 0..9 show the standard patterns: 0=7'h01, 1=7'h4F, 2=7'h12, 3=7'h06, 4=7'h4C, 5=7'h24, 6=7'h20, 7=7'h0F, 8=7'h00, 9=7'h04.
- R2: Codes 10..15 light only segment g (7'h7E) on any digit that is not blanked.
- R3: When `lamp_test_n` is 0 and `blank_n` is 1, every segment of every digit is lit (7'h00). This holds whatever the BCD values and whatever the zero-blanking state.
- R4: When `blank_n` is 0, every segment of every digit is dark (7'h7F), whatever the other inputs.
- R5: In the integer part, every zero digit to the left of the most significant nonzero integer digit is dark.
- R6: The units digit (integer digit 0, bits [3:0] and [6:0]) shows 0 even when all higher integer digits are zero.
- R7: In the fraction part, every zero digit to the right of the last nonzero fraction digit is dark. Fraction digit 0 is the rightmost digit.
- R8: The first fraction digit (the highest index, next to the point) shows 0 even when all fraction digits are zero.
- R9: A zero that lies between nonzero digits, or between a nonzero digit and the point, is shown.
- R10: While `rst` is high at a clock edge, all segment outputs become 7'h7F. Otherwise the outputs reflect the inputs sampled at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| int_bcd | input | 4*INT_DIGITS | Integer BCD digits; digit 0 (units) in bits [3:0] |
| frac_bcd | input | 4*FRAC_DIGITS | Fraction BCD digits; digit 0 (rightmost) in bits [3:0] |
| lamp_test_n | input | 1 | Active-low lamp test |
| blank_n | input | 1 | Active-low blanking of the whole row |
| int_seg_n | output | 7*INT_DIGITS | Integer segment lines, active low, 7 bits per digit |
| frac_seg_n | output | 7*FRAC_DIGITS | Fraction segment lines, active low, 7 bits per digit |

## Verification
The assertions check on every cycle the behaviours that follow from the previous cycle's inputs alone:
- the reset value;
- full blanking;
- lamp test;
- the dash shown for codes above nine on the units digit;
- the always-visible zero on the units digit and on the first fraction digit.

Only the bench's scenarios can show the suppression behaviour across the chain: which zeros go dark depends on the values of the neighbouring digits. The bench covers leading runs, trailing runs, embedded zeros and all-zero rows against a model built from the requirements.

// File: rtl/seg_display_pkg.sv
package seg_display_pkg;

    localparam int SEG_W = 7;
    localparam int BCD_W = 4;

    typedef logic [SEG_W-1:0] seg_t;   // bit 6 = a ... bit 0 = g, active low
    typedef logic [BCD_W-1:0] bcd_t;

    localparam seg_t SEG_DARK = 7'h7F;
    localparam seg_t SEG_FULL = 7'h00;
    localparam seg_t SEG_DASH = 7'h7E;

    typedef struct packed {
        bcd_t code;
        logic lamp_test_n;
        logic blank_n;
        logic rbi_n;
    } dec_in_t;

    typedef struct packed {
        seg_t seg_n;
        logic rbo_n;
    } dec_out_t;

    function automatic seg_t glyph(input bcd_t code);
        seg_t lit;   // active-high abcdefg
        case (code)
            4'd0: lit = 7'b1111110;
            4'd1: lit = 7'b0110000;
            4'd2: lit = 7'b1101101;
            4'd3: lit = 7'b1111001;
            4'd4: lit = 7'b0110011;
            4'd5: lit = 7'b1011011;
            4'd6: lit = 7'b1011111;
            4'd7: lit = 7'b1110000;
            4'd8: lit = 7'b1111111;
            4'd9: lit = 7'b1111011;
            default: lit = 7'b0000001;
        endcase
        return ~lit;
    endfunction

endpackage

// File: rtl/seg_digit_dec.sv
module seg_digit_dec
    import seg_display_pkg::*;
(
    input  dec_in_t  din,
    output dec_out_t dout
);
    logic zero_code;

    always_comb begin
        zero_code = (din.code == '0);
        // ripple output only when this digit itself is suppressed as a zero
        dout.rbo_n = !(zero_code && !din.rbi_n && din.lamp_test_n);
        if (!din.blank_n)
            dout.seg_n = SEG_DARK;
        else if (!din.lamp_test_n)
            dout.seg_n = SEG_FULL;
        else if (zero_code && !din.rbi_n)
            dout.seg_n = SEG_DARK;
        else
            dout.seg_n = glyph(din.code);
    end
endmodule

// File: rtl/seg_zero_chain.sv
module seg_zero_chain
    import seg_display_pkg::*;
#(
    parameter int NUM     = 4,
    parameter bit LEADING = 1'b1   // 1: chain from top index down; 0: from index 0 up
) (
    input  logic [NUM*BCD_W-1:0] digits,
    input  logic                 lamp_test_n,
    input  logic                 blank_n,
    output logic [NUM*SEG_W-1:0] seg_n
);
    logic [NUM-1:0] rbo_n;
    logic [NUM-1:0] rbi_n;

    for (genvar k = 0; k < NUM; k++) begin : g_dig
        dec_in_t  din;
        dec_out_t dout;

        if (LEADING) begin : g_lead
            if (k == 0)             begin : g_keep assign rbi_n[k] = 1'b1;         end
            else if (k == NUM - 1)  begin : g_head assign rbi_n[k] = 1'b0;         end
            else                    begin : g_link assign rbi_n[k] = rbo_n[k+1];   end
        end else begin : g_trail
            if (k == NUM - 1)       begin : g_keep assign rbi_n[k] = 1'b1;         end
            else if (k == 0)        begin : g_head assign rbi_n[k] = 1'b0;         end
            else                    begin : g_link assign rbi_n[k] = rbo_n[k-1];   end
        end

        assign din.code        = digits[k*BCD_W +: BCD_W];
        assign din.lamp_test_n = lamp_test_n;
        assign din.blank_n     = blank_n;
        assign din.rbi_n       = rbi_n[k];

        seg_digit_dec u_dec (.din(din), .dout(dout));

        assign rbo_n[k]               = dout.rbo_n;
        assign seg_n[k*SEG_W +: SEG_W] = dout.seg_n;
    end
endmodule

// File: rtl/seg_display.sv
module seg_display
    import seg_display_pkg::*;
#(
    parameter int INT_DIGITS  = 4,
    parameter int FRAC_DIGITS = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [INT_DIGITS*BCD_W-1:0]  int_bcd,
    input  logic [FRAC_DIGITS*BCD_W-1:0] frac_bcd,
    input  logic                         lamp_test_n,
    input  logic                         blank_n,
    output logic [INT_DIGITS*SEG_W-1:0]  int_seg_n,
    output logic [FRAC_DIGITS*SEG_W-1:0] frac_seg_n
);
    localparam int INT_SW  = INT_DIGITS * SEG_W;
    localparam int FRAC_SW = FRAC_DIGITS * SEG_W;

    logic [INT_SW-1:0]  int_nxt;
    logic [FRAC_SW-1:0] frac_nxt;

    seg_zero_chain #(.NUM(INT_DIGITS), .LEADING(1'b1)) u_int (
        .digits(int_bcd), .lamp_test_n(lamp_test_n), .blank_n(blank_n), .seg_n(int_nxt)
    );

    seg_zero_chain #(.NUM(FRAC_DIGITS), .LEADING(1'b0)) u_frac (
        .digits(frac_bcd), .lamp_test_n(lamp_test_n), .blank_n(blank_n), .seg_n(frac_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            int_seg_n  <= {INT_DIGITS{SEG_DARK}};
            frac_seg_n <= {FRAC_DIGITS{SEG_DARK}};
        end else begin
            int_seg_n  <= int_nxt;
            frac_seg_n <= frac_nxt;
        end
    end
endmodule

// File: rtl/seg_display_chk.sv
module seg_display_chk #(
    parameter int INT_DIGITS  = 4,
    parameter int FRAC_DIGITS = 2
) (
    input logic                       clk,
    input logic                       rst,
    input logic [3:0]                 units_bcd,
    input logic [3:0]                 first_frac_bcd,
    input logic                       lamp_test_n,
    input logic                       blank_n,
    input logic [INT_DIGITS*7-1:0]    int_seg_n,
    input logic [FRAC_DIGITS*7-1:0]   frac_seg_n
);
    a_r10_reset_dark: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (&int_seg_n && &frac_seg_n));

    a_r4_blank_all: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(blank_n)) |-> (&int_seg_n && &frac_seg_n));

    a_r3_lamp_all: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(blank_n) && !$past(lamp_test_n))
        |-> (int_seg_n == '0 && frac_seg_n == '0));

    a_r2_units_dash: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(blank_n) && $past(lamp_test_n) && $past(units_bcd) > 4'd9)
        |-> (int_seg_n[6:0] == 7'h7E));

    a_r6_units_zero: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(blank_n) && $past(lamp_test_n) && $past(units_bcd) == 4'd0)
        |-> (int_seg_n[6:0] == 7'h01));

    a_r8_first_frac_zero: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(blank_n) && $past(lamp_test_n) && $past(first_frac_bcd) == 4'd0)
        |-> (frac_seg_n[FRAC_DIGITS*7-1 -: 7] == 7'h01));
endmodule

bind seg_display seg_display_chk #(.INT_DIGITS(INT_DIGITS), .FRAC_DIGITS(FRAC_DIGITS)) u_chk (
    .clk(clk), .rst(rst),
    .units_bcd(int_bcd[3:0]),
    .first_frac_bcd(frac_bcd[FRAC_DIGITS*4-1 -: 4]),
    .lamp_test_n(lamp_test_n), .blank_n(blank_n),
    .int_seg_n(int_seg_n), .frac_seg_n(frac_seg_n)
);

// File: tb/tb_seg_display.sv
module tb_seg_display;
    localparam int CLK_PERIOD = 10;
    localparam int NI = 4;
    localparam int NF = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NI*4-1:0] int_bcd = '0;
    logic [NF*4-1:0] frac_bcd = '0;
    logic lamp_test_n = 1'b1;
    logic blank_n = 1'b1;
    logic [NI*7-1:0] int_seg_n;
    logic [NF*7-1:0] frac_seg_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_display #(.INT_DIGITS(NI), .FRAC_DIGITS(NF)) dut (
        .clk(clk), .rst(rst), .int_bcd(int_bcd), .frac_bcd(frac_bcd),
        .lamp_test_n(lamp_test_n), .blank_n(blank_n),
        .int_seg_n(int_seg_n), .frac_seg_n(frac_seg_n)
    );

    function automatic logic [6:0] pat(input logic [3:0] d);
        case (d)
            4'd0: return 7'h01;  4'd1: return 7'h4F;  4'd2: return 7'h12;
            4'd3: return 7'h06;  4'd4: return 7'h4C;  4'd5: return 7'h24;
            4'd6: return 7'h20;  4'd7: return 7'h0F;  4'd8: return 7'h00;
            4'd9: return 7'h04;  default: return 7'h7E;
        endcase
    endfunction

    function automatic logic [NI*7-1:0] exp_int(input logic [NI*4-1:0] v, input logic lt, input logic bi);
        logic [NI*7-1:0] r;
        bit lead = 1'b1;
        for (int k = NI-1; k >= 0; k--) begin
            logic [3:0] d = v[k*4 +: 4];
            if (!bi) r[k*7 +: 7] = 7'h7F;
            else if (!lt) r[k*7 +: 7] = 7'h00;
            else if (lead && d == 0 && k != 0) r[k*7 +: 7] = 7'h7F;
            else begin lead = 1'b0; r[k*7 +: 7] = pat(d); end
        end
        return r;
    endfunction

    function automatic logic [NF*7-1:0] exp_frac(input logic [NF*4-1:0] v, input logic lt, input logic bi);
        logic [NF*7-1:0] r;
        bit tail = 1'b1;
        for (int k = 0; k < NF; k++) begin
            logic [3:0] d = v[k*4 +: 4];
            if (!bi) r[k*7 +: 7] = 7'h7F;
            else if (!lt) r[k*7 +: 7] = 7'h00;
            else if (tail && d == 0 && k != NF-1) r[k*7 +: 7] = 7'h7F;
            else begin tail = 1'b0; r[k*7 +: 7] = pat(d); end
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [NI*7-1:0] ei, input logic [NF*7-1:0] ef);
        n_tests++;
        if (int_seg_n !== ei || frac_seg_n !== ef) begin
            n_fail++;
            $display("FAIL %s: int=%h frac=%h expected int=%h frac=%h", req, int_seg_n, frac_seg_n, ei, ef);
        end
    endtask

    // drive away from the edge, let the register capture, sample mid-cycle
    task automatic apply(input logic [NI*4-1:0] iv, input logic [NF*4-1:0] fv, input logic lt, input logic bi);
        @(negedge clk);
        int_bcd = iv; frac_bcd = fv; lamp_test_n = lt; blank_n = bi;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run(input string req, input logic [NI*4-1:0] iv, input logic [NF*4-1:0] fv,
                       input logic lt, input logic bi);
        apply(iv, fv, lt, bi);
        check(req, exp_int(iv, lt, bi), exp_frac(fv, lt, bi));
    endtask

    task automatic t_reset;
        rst = 1'b1;
        int_bcd = 16'h1234; frac_bcd = 8'h56;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R10 reset dark", '1, '1);
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R10 one-cycle update", exp_int(16'h1234, 1, 1), exp_frac(8'h56, 1, 1));
    endtask

    task automatic t_glyphs;
        for (int d = 0; d < 16; d++) begin
            apply({4'd1, 4'd1, 4'd1, 4'(d)}, {4'(d), 4'(d)}, 1'b1, 1'b1);
            n_tests++;
            if (int_seg_n[6:0] !== pat(4'(d)) || frac_seg_n[13:7] !== pat(4'(d))) begin
                n_fail++;
                $display("FAIL %s: code %0d got %h/%h expected %h", (d < 10) ? "R1" : "R2",
                         d, int_seg_n[6:0], frac_seg_n[13:7], pat(4'(d)));
            end
        end
        run("R1 mixed row", 16'h9876, 8'h54, 1, 1);
        run("R2 dashes", 16'hABCD, 8'hEF, 1, 1);
    endtask

    task automatic t_lamp;
        run("R3 lamp over zeros", 16'h0000, 8'h00, 0, 1);
        n_tests++;
        if (int_seg_n !== '0 || frac_seg_n !== '0) begin
            n_fail++;
            $display("FAIL R3: int=%h frac=%h expected all 0", int_seg_n, frac_seg_n);
        end
        run("R3 lamp over digits", 16'h12F4, 8'h30, 0, 1);
    endtask

    task automatic t_blank;
        run("R4 blank", 16'h1234, 8'h56, 1, 0);
        run("R4 blank beats lamp", 16'h0007, 8'h80, 0, 0);
    endtask

    task automatic t_leading;
        run("R5 three leading zeros", 16'h0007, 8'h11, 1, 1);
        run("R5 two leading zeros", 16'h0042, 8'h11, 1, 1);
        run("R5 one leading zero", 16'h0905, 8'h11, 1, 1);
        run("R6 all integer zero", 16'h0000, 8'h25, 1, 1);
    endtask

    task automatic t_trailing;
        run("R7 trailing zero", 16'h1000, 8'h50, 1, 1);
        run("R8 all fraction zero", 16'h0003, 8'h00, 1, 1);
    endtask

    task automatic t_embedded;
        run("R9 inner integer zeros", 16'h1003, 8'h07, 1, 1);
        run("R9 zero before point", 16'h0020, 8'h09, 1, 1);
        run("R9 fraction zero after point", 16'h0001, 8'h05, 1, 1);
    endtask

    initial begin
        t_reset();
        t_glyphs();
        t_lamp();
        t_blank();
        t_leading();
        t_trailing();
        t_embedded();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: run did not finish, expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule